// File: doc/BRIEF.md
# Set-Associative Hit/Miss Tracker with Age-Based Replacement

This block models the tag side of an N-way set-associative cache so that the hit and miss behaviour of an address stream can be measured in hardware. It holds no data. Each way keeps the full access address in place of a tag, a valid flag, and an age counter. An external mapper chooses the set. It presents that set index together with the address. The block answers whether the address was present and which way it now occupies. It also keeps running totals of accesses, hits and misses.

Replacement follows ages. Every access makes its way the youngest (age zero) and makes every other valid way in the same set one step older. A miss in a full set therefore replaces the oldest line. Each access is a single read-modify-write of one set. Requests use a valid/ready handshake. `req_ready` stays low during reset and for the first clock after it. After that it stays high, so the block never applies back-pressure once it is running. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_set` and `req_addr` must be stable at that edge. The result is a single-cycle pulse on `rsp_valid` with no ready, so the consumer must take it in that cycle.

Top module: `cache_lru_tracker`

## Requirements
- R1: The block has NUM_BLOCKS/WAYS sets, with WAYS being 1, 2 or 4. Ways in one set are never compared with or changed by an access to another set, so the same address can be resident in several sets at once.
- R2: An access hits (`rsp_hit`=1) only when a valid way of the selected set holds an address equal to `req_addr` in every bit. `rsp_way` then gives that way and no line is replaced (`rsp_evict`=0).
- R3: A miss in a set that still has an invalid way writes the address into the lowest-numbered invalid way. `rsp_way` reports that way and `rsp_evict`=0.
- R4: A miss in a set whose ways are all valid replaces the way with the largest age. Among equal ages the lowest-numbered way is chosen. `rsp_way` reports that way and `rsp_evict`=1.
- R5: After every accepted access, the accessed way has age 0. Every other valid way in that set gains 1, holding at 2^AGE_W-1 instead of wrapping.
- R6: `stat_total`, `stat_hits` and `stat_misses` count accepted accesses, hits and misses. Each one changes in the same cycle as the `rsp_valid` pulse for its access.
- R7: `rsp_valid` is high for exactly one cycle, in the cycle after each accepted request, and is low otherwise. `req_ready` is high from the second clock after reset onwards.
- R8: Synchronous reset (`rst`=1) clears every valid flag, every age and all three counters, and holds `rsp_valid` and `req_ready` low. An address that was resident before reset misses after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept a request |
| req_set | input | SET_W | Set index from the external mapper |
| req_addr | input | ADDR_W | Full access address |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_hit | output | 1 | Access found the address |
| rsp_evict | output | 1 | A valid line was replaced |
| rsp_way | output | WAY_W | Way that now holds the address |
| stat_total | output | CNT_W | Accepted access count |
| stat_hits | output | CNT_W | Hit count |
| stat_misses | output | CNT_W | Miss count |

## Verification
A wrong age or valid flag cannot be seen at once. It first shows up at the ports when its set next misses while full: the pulse names a different victim way than the reference model expects, and the later hit/miss sequence of that set then drifts. A wrong stored address shows at the first re-access to that line as a false hit or a false miss. The bench keeps a small pool of addresses that compete for four ways. It also runs long hit sequences so that ages saturate and tie. These make stale state affect a victim choice within a few accesses.

// File: rtl/cache_lru_pkg.sv
package cache_lru_pkg;

  // Outcome of one access, used to steer the response flags.
  typedef enum logic [1:0] {
    OUTC_HIT   = 2'd0,
    OUTC_FILL  = 2'd1,
    OUTC_EVICT = 2'd2
  } access_outcome_e;

  // Saturating increment for an age field held in a 32-bit container.
  function automatic int unsigned sat_step(input int unsigned cur, input int unsigned top);
    return (cur >= top) ? top : cur + 1;
  endfunction

endpackage

// File: rtl/cache_lru_lookup.sv
module cache_lru_lookup #(
  parameter int WAYS   = 2,
  parameter int ADDR_W = 32,
  parameter int AGE_W  = 8,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]             set_valid,
  input  logic [WAYS-1:0][ADDR_W-1:0] set_addr,
  input  logic [WAYS-1:0][AGE_W-1:0]  set_age,
  input  logic [ADDR_W-1:0]           addr,
  output logic [WAYS-1:0]             hit_vec,
  output cache_lru_pkg::access_outcome_e outcome,
  output logic [WAY_W-1:0]            sel_way
);
  import cache_lru_pkg::*;

  logic [WAY_W-1:0] hit_way, free_way, old_way;
  logic             any_hit, any_free;
  logic [AGE_W-1:0] old_age;

  // Per-way address compare, qualified by the valid flag.
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = set_valid[w] && (set_addr[w] == addr);
  end

  // Encoders: hit way, lowest invalid way, oldest way (lowest index on tie).
  always_comb begin
    any_hit  = 1'b0;
    any_free = 1'b0;
    hit_way  = '0;
    free_way = '0;
    old_way  = '0;
    old_age  = set_age[0];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        any_hit = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (!set_valid[w]) begin
        any_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    for (int w = 1; w < WAYS; w++) begin
      if (set_age[w] > old_age) begin
        old_age = set_age[w];
        old_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    if (any_hit) begin
      outcome = OUTC_HIT;
      sel_way = hit_way;
    end else if (any_free) begin
      outcome = OUTC_FILL;
      sel_way = free_way;
    end else begin
      outcome = OUTC_EVICT;
      sel_way = old_way;
    end
  end

endmodule

// File: rtl/cache_lru_age_update.sv
module cache_lru_age_update #(
  parameter int WAYS  = 2,
  parameter int AGE_W = 8,
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int AGE_TOP = (1 << AGE_W) - 1
) (
  input  logic [WAYS-1:0]            set_valid,
  input  logic [WAYS-1:0][AGE_W-1:0] set_age,
  input  logic [WAY_W-1:0]           sel_way,
  output logic [WAYS-1:0]            new_valid,
  output logic [WAYS-1:0][AGE_W-1:0] new_age
);
  import cache_lru_pkg::*;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_comb begin
      if (WAY_W'(w) == sel_way) begin
        new_valid[w] = 1'b1;
        new_age[w]   = '0;
      end else if (set_valid[w]) begin
        new_valid[w] = 1'b1;
        new_age[w]   = AGE_W'(sat_step(int'(set_age[w]), AGE_TOP));
      end else begin
        new_valid[w] = 1'b0;
        new_age[w]   = '0;
      end
    end
  end

endmodule

// File: rtl/cache_lru_stats.sv
module cache_lru_stats #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_valid,
  input  logic             evt_hit,
  output logic [CNT_W-1:0] total,
  output logic [CNT_W-1:0] hits,
  output logic [CNT_W-1:0] misses
);

  always_ff @(posedge clk) begin
    if (rst) begin
      total  <= '0;
      hits   <= '0;
      misses <= '0;
    end else if (evt_valid) begin
      total <= total + 1'b1;
      if (evt_hit) hits   <= hits + 1'b1;
      else         misses <= misses + 1'b1;
    end
  end

  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (rst)
    evt_valid |=> total == CNT_W'($past(total) + 1)) // R6
    else $error("total did not advance");

  AST_SPLIT_SUM: assert property (@(posedge clk) disable iff (rst)
    total == CNT_W'(hits + misses)) // R6
    else $error("hits plus misses differs from total");

endmodule

// File: rtl/cache_lru_tracker.sv
module cache_lru_tracker #(
  parameter int NUM_BLOCKS = 2048,
  parameter int WAYS       = 2,
  parameter int ADDR_W     = 32,
  parameter int AGE_W      = 8,
  parameter int CNT_W      = 32,
  localparam int NUM_SETS  = NUM_BLOCKS / WAYS,
  localparam int SET_W     = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SET_W-1:0]  req_set,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_evict,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [CNT_W-1:0]  stat_total,
  output logic [CNT_W-1:0]  stat_hits,
  output logic [CNT_W-1:0]  stat_misses
);
  import cache_lru_pkg::*;

  // Per-set state: valid flags, full addresses and ages.
  logic [WAYS-1:0]             valid_q [NUM_SETS];
  logic [WAYS-1:0][ADDR_W-1:0] addr_q  [NUM_SETS];
  logic [WAYS-1:0][AGE_W-1:0]  age_q   [NUM_SETS];

  logic                        acc;
  logic [WAYS-1:0]             cur_valid, upd_valid, hit_vec;
  logic [WAYS-1:0][ADDR_W-1:0] cur_addr;
  logic [WAYS-1:0][AGE_W-1:0]  cur_age, upd_age;
  logic [WAY_W-1:0]            sel_way;
  access_outcome_e             outcome;
  logic                        ready_q;

  assign req_ready = ready_q;
  assign acc       = req_valid && ready_q;
  assign cur_valid = valid_q[req_set];
  assign cur_addr  = addr_q[req_set];
  assign cur_age   = age_q[req_set];

  cache_lru_lookup #(.WAYS(WAYS), .ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_lookup (
    .set_valid (cur_valid),
    .set_addr  (cur_addr),
    .set_age   (cur_age),
    .addr      (req_addr),
    .hit_vec   (hit_vec),
    .outcome   (outcome),
    .sel_way   (sel_way)
  );

  cache_lru_age_update #(.WAYS(WAYS), .AGE_W(AGE_W)) u_age (
    .set_valid (cur_valid),
    .set_age   (cur_age),
    .sel_way   (sel_way),
    .new_valid (upd_valid),
    .new_age   (upd_age)
  );

  cache_lru_stats #(.CNT_W(CNT_W)) u_stats (
    .clk       (clk),
    .rst       (rst),
    .evt_valid (acc),
    .evt_hit   (outcome == OUTC_HIT),
    .total     (stat_total),
    .hits      (stat_hits),
    .misses    (stat_misses)
  );

  // Read-modify-write of the selected set; flags and ages are reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_q[s] <= '0;
        age_q[s]   <= '0;
      end
    end else if (acc) begin
      valid_q[req_set] <= upd_valid;
      age_q[req_set]   <= upd_age;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) addr_q[req_set][sel_way] <= req_addr;
  end

  // Response pulse and ready flag.
  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_evict <= 1'b0;
      rsp_way   <= '0;
    end else begin
      ready_q   <= 1'b1;
      rsp_valid <= acc;
      if (acc) begin
        rsp_hit   <= (outcome == OUTC_HIT);
        rsp_evict <= (outcome == OUTC_EVICT);
        rsp_way   <= sel_way;
      end
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_valid) // R7
    else $error("missing response pulse");

  AST_RSP_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !rsp_valid) // R7
    else $error("spurious response pulse");

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    acc |-> $onehot0(hit_vec)) // R2
    else $error("address resident in two ways");

  AST_HIT_NO_EVICT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_hit && rsp_evict)) // R2
    else $error("hit reported a replacement");

  AST_EVICT_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    acc && (cur_valid != '1) |=> !rsp_evict) // R3
    else $error("replacement while a way was free");

  for (genvar w = 0; w < WAYS; w++) begin : g_chk
    AST_AGE_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
      acc && cur_valid[w] && (sel_way != WAY_W'(w)) |-> upd_age[w] >= cur_age[w]) // R5
      else $error("age wrapped");
  end

endmodule

// File: tb/cache_lru_tracker_bench.sv
module cache_lru_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BLOCKS     = 64;
  localparam int WAYS       = 4;
  localparam int ADDR_W     = 32;
  localparam int AGE_W      = 3;
  localparam int CNT_W      = 32;
  localparam int NSETS      = BLOCKS / WAYS;
  localparam int SET_W      = $clog2(NSETS);
  localparam int WAY_W      = $clog2(WAYS);
  localparam int AGE_MAX    = (1 << AGE_W) - 1;
  localparam int WATCHDOG   = 100000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [SET_W-1:0]  req_set = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              rsp_valid, rsp_hit, rsp_evict;
  logic [WAY_W-1:0]  rsp_way;
  logic [CNT_W-1:0]  stat_total, stat_hits, stat_misses;

  cache_lru_tracker #(
    .NUM_BLOCKS(BLOCKS), .WAYS(WAYS), .ADDR_W(ADDR_W), .AGE_W(AGE_W), .CNT_W(CNT_W)
  ) u_cache_lru_tracker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_set(req_set), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_evict(rsp_evict), .rsp_way(rsp_way),
    .stat_total(stat_total), .stat_hits(stat_hits), .stat_misses(stat_misses)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Behavioural reference state.
  bit          m_valid [NSETS][WAYS];
  logic [31:0] m_addr  [NSETS][WAYS];
  int          m_age   [NSETS][WAYS];
  bit          e_valid, e_hit, e_evict;
  int          e_way;
  int          e_total, e_hits, e_misses;
  int          checks, fails;
  bit          done;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < NSETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_valid[s][w] = 1'b0;
        m_age[s][w]   = 0;
      end
    e_valid = 0; e_total = 0; e_hits = 0; e_misses = 0;
  endtask

  task automatic model_access(input int s, input logic [31:0] a);
    int way;
    int best;
    way = -1;
    for (int w = 0; w < WAYS; w++)
      if (m_valid[s][w] && m_addr[s][w] == a) way = w;
    e_hit = (way >= 0);
    e_evict = 0;
    if (!e_hit) begin
      for (int w = WAYS - 1; w >= 0; w--)
        if (!m_valid[s][w]) way = w;
      if (way < 0) begin
        e_evict = 1;
        best = -1;
        for (int w = 0; w < WAYS; w++)
          if (m_age[s][w] > best) begin
            best = m_age[s][w];
            way = w;
          end
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (w == way) begin
        m_valid[s][w] = 1'b1;
        m_addr[s][w]  = a;
        m_age[s][w]   = 0;
      end else if (m_valid[s][w]) begin
        m_age[s][w] = (m_age[s][w] < AGE_MAX) ? m_age[s][w] + 1 : AGE_MAX;
      end
    end
    e_way = way;
    e_valid = 1;
    e_total++;
    if (e_hit) e_hits++;
    else e_misses++;
  endtask

  task automatic compare();
    check("R7 rsp_valid", rsp_valid, e_valid);
    if (e_valid) begin
      check("R1,R2 rsp_hit", rsp_hit, e_hit);
      check(e_hit ? "R2 rsp_way" : (e_evict ? "R4,R5 rsp_way" : "R3 rsp_way"), rsp_way, e_way);
      check("R3,R4 rsp_evict", rsp_evict, e_evict);
    end
    check("R6 stat_total", stat_total, e_total);
    check("R6 stat_hits", stat_hits, e_hits);
    check("R6 stat_misses", stat_misses, e_misses);
  endtask

  // One clock: check the previous result, then drive the next request.
  task automatic step(input bit v, input int s, input logic [31:0] a);
    @(negedge clk);
    compare();
    req_valid = v;
    req_set   = SET_W'(s);
    req_addr  = a;
    if (v && req_ready) model_access(s, a);
    else e_valid = 0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    model_clear();
    repeat (2) begin
      @(negedge clk);
      // R8: outputs and counters cleared while reset is held
      check("R8 rsp_valid", rsp_valid, 0);
      check("R8 req_ready", req_ready, 0);
      check("R8 stat_total", stat_total, 0);
      check("R8 stat_hits", stat_hits, 0);
      check("R8 stat_misses", stat_misses, 0);
    end
    rst = 1'b0;
    step(0, 0, 0);
    step(0, 0, 0);
    check("R7 req_ready", req_ready, 1);
  endtask

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    done = 0;
    checks = 0;
    fails = 0;
    model_clear();
    apply_reset();

    // R3 fill order then R2 hits then R4 oldest replacement
    for (int i = 0; i < 4; i++) step(1, 3, 32'h1000 + i);
    step(1, 3, 32'h1002);
    step(1, 3, 32'h1000);
    step(0, 0, 0);
    step(1, 3, 32'h2000);
    step(1, 3, 32'h1001);

    // R5 saturation and R4 tie: three ways reach AGE_MAX together
    for (int i = 0; i < 4; i++) step(1, 5, 32'h50 + i);
    for (int i = 0; i < 2 * AGE_MAX; i++) step(1, 5, 32'h53);
    step(1, 5, 32'h60);
    step(1, 5, 32'h60);
    step(1, 5, 32'h61);

    // R1: same address in two sets is held separately
    step(1, 0, 32'hBEEF);
    step(1, 1, 32'hBEEF);
    step(1, 0, 32'hBEEF);
    step(1, 1, 32'hBEEF);

    // Mixed traffic: small address pool competing for few sets
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[1:0] != 2'b00, int'(lfsr[3:2]), {29'h0, lfsr[8:6]});
    end
    step(0, 0, 0);

    // R8: resident address misses after reset
    step(1, 7, 32'h777);
    step(1, 7, 32'h777);
    apply_reset();
    step(1, 7, 32'h777);
    step(0, 0, 0);
    step(0, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R7: watchdog expired, actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule